// File: doc/BRIEF.md
# Block Cipher Start Controller

This block is the register-facing control unit that sits in front of a block-cipher datapath. Software reaches it through a single-cycle write port and a combinational read port. It accepts a mode word, the first key word, four IV/counter words and four input-data words. It then decides when a block begins processing: either on a software start command, or on its own once every input word that the selected chaining mode accepts has been written. It follows which of those words have arrived since the last block began, rejects and flags writes to words the mode does not accept, and holds a data-ready status. That status drives an interrupt line and is cleared when software reads any output word.

The cipher itself is a stand-in with a fixed latency of `LATENCY` cycles (default 10). When a block starts, the core latches each input word XORed with key word 0 and with the matching IV word, leaving the IV out in ECB. That value becomes visible in the output words when the block completes. Key words other than word 0 may be written, but they have no effect on the stand-in.

Top module: `cipher_start_ctrl`

## Requirements
- R1: In manual mode (mode bit 0 = 0), a write of 1 to bit 0 of the control register (address 0x00) starts a block when the core is idle, and busy (status bit 1, status at address 0x03) reads 1 from the next cycle on.
- R2: In automatic mode (mode bit 0 = 1), a block starts on the clock edge one cycle after the write that completes the set of accepted input words, and a control-register start write has no effect.
- R3: The mode register (address 0x01) holds chaining mode in bits 3:1 (0 ECB, 1 CBC, 2 OFB, 3 CFB, 4 CTR) and feedback size in bits 6:4 (0 = 128, 1 = 64, 2 = 32, 3 = 16, 4 = 8 bits). Input words sit at 0x14 to 0x17. All four are accepted, except in CFB, where a 64-bit feedback size accepts words 0 and 1 and smaller sizes accept word 0 only.
- R4: A write to an input word that the mode does not accept leaves the stored word unchanged, does not count toward an automatic start, and sets the error flag (status bit 2); a mode-register write clears that flag.
- R5: The record of written input words is emptied whenever a block starts, so the next automatic start needs a new full set of writes.
- R6: While busy, a start write is ignored. An automatic trigger reached while busy is dropped and empties the written-word record. Neither of them alters the running block.
- R7: Data-ready (status bit 0) rises exactly LATENCY cycles after the start edge, on the same edge that busy falls.
- R8: Output word i (addresses 0x18 to 0x1B) equals input word i XOR key word 0 (address 0x08) XOR IV word i (0x10 to 0x13). The IV term is left out in ECB.
- R9: The irq output is high exactly when data-ready is set and bit 0 of the interrupt-enable register (address 0x02) is 1.
- R10: A read of any output word clears data-ready; reads of other addresses leave it set.
- R11: After reset, the status, mode and interrupt-enable registers read 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Write address |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Register read strobe (side effects only) |
| rdAddr | input | 6 | Read address |
| rdData | output | 32 | Combinational read data for rdAddr |
| irq | output | 1 | Data-ready interrupt |

## Verification
Several properties are checked on every cycle by the assertions. The written-word record never holds a word that the current mode rejects. A rejected write sets the error flag and leaves the record untouched. The latency counter steps down by one each busy cycle, and no start can disturb a running block. Completion always sets data-ready, and an output read without a coincident completion clears it. Other behaviours can only be shown by the bench scenarios, because they depend on the order of writes: an automatic start firing exactly one cycle after the final accepted word, a half-written set never starting after a block, a trigger dropped while busy, and the XOR result per mode.

// File: rtl/csc_pkg.sv
`timescale 1ns/1ps
package csc_pkg;
  localparam int DATA_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int ADDR_W    = 6;
  localparam int IDX_W     = $clog2(BLK_WORDS);

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_MODE  = 6'h01;
  localparam logic [ADDR_W-1:0] A_IRQEN = 6'h02;
  localparam logic [ADDR_W-1:0] A_STAT  = 6'h03;
  localparam logic [ADDR_W-1:0] A_KEY0  = 6'h08;
  localparam logic [ADDR_W-1:0] A_IV0   = 6'h10;
  localparam logic [ADDR_W-1:0] A_IN0   = 6'h14;
  localparam logic [ADDR_W-1:0] A_OUT0  = 6'h18;

  typedef enum logic [2:0] {CH_ECB = 3'd0, CH_CBC = 3'd1, CH_OFB = 3'd2,
                            CH_CFB = 3'd3, CH_CTR = 3'd4} chain_e;
  typedef enum logic [2:0] {FB_128 = 3'd0, FB_64 = 3'd1, FB_32 = 3'd2,
                            FB_16 = 3'd3, FB_8 = 3'd4} fbsz_e;

  typedef logic [BLK_WORDS-1:0][DATA_W-1:0] blk_t;

  typedef struct packed {
    logic                 start;
    logic                 skipIv;
    logic                 keyWr;
    logic [BLK_WORDS-1:0] ivWr;
    logic [BLK_WORDS-1:0] inWr;
    logic [DATA_W-1:0]    data;
  } dp_strobe_t;

  // Input words a mode accepts: a run of ones from word 0 upward.
  function automatic logic [BLK_WORDS-1:0] permitMask(input logic [2:0] ch,
                                                      input logic [2:0] fb);
    int n;
    logic [BLK_WORDS-1:0] m;
    if (ch != CH_CFB)     n = BLK_WORDS;
    else if (fb == FB_128) n = BLK_WORDS;
    else if (fb == FB_64)  n = BLK_WORDS / 2;
    else                   n = 1;
    for (int i = 0; i < BLK_WORDS; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/csc_ctrl.sv
`timescale 1ns/1ps
module csc_ctrl
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              coreBusy,
  input  logic              coreDone,
  input  blk_t              outWords,
  output dp_strobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic                 modeAuto, irqEn, ready, err;
  logic [2:0]           chain, fbSel;
  logic [BLK_WORDS-1:0] wrMask, permit, wordSel;
  logic [IDX_W-1:0]     wrIdx, rdIdx;
  logic wrIvHit, wrInHit, rdOutHit, inWrOk, inWrBad;
  logic modeWr, manualGo, autoFull, goReq, outRead;

  assign wrIdx    = wrAddr[IDX_W-1:0];
  assign rdIdx    = rdAddr[IDX_W-1:0];
  assign wrIvHit  = wrEn && (wrAddr[ADDR_W-1:IDX_W] == A_IV0[ADDR_W-1:IDX_W]);
  assign wrInHit  = wrEn && (wrAddr[ADDR_W-1:IDX_W] == A_IN0[ADDR_W-1:IDX_W]);
  assign rdOutHit = rdAddr[ADDR_W-1:IDX_W] == A_OUT0[ADDR_W-1:IDX_W];
  assign wordSel  = BLK_WORDS'(1) << wrIdx;
  assign permit   = permitMask(chain, fbSel);
  assign inWrOk   = wrInHit && permit[wrIdx];
  assign inWrBad  = wrInHit && !permit[wrIdx];
  assign modeWr   = wrEn && (wrAddr == A_MODE);
  assign manualGo = wrEn && (wrAddr == A_CTRL) && wrData[0] && !modeAuto;
  assign autoFull = modeAuto && (wrMask == permit);
  assign goReq    = manualGo || autoFull;
  assign outRead  = rdEn && rdOutHit;

  always_comb begin
    strobe.start  = goReq && !coreBusy;
    strobe.skipIv = (chain == CH_ECB);
    strobe.keyWr  = wrEn && (wrAddr == A_KEY0);
    strobe.ivWr   = wrIvHit ? wordSel : '0;
    strobe.inWr   = inWrOk  ? wordSel : '0;
    strobe.data   = wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeAuto <= 1'b0;
      chain    <= CH_ECB;
      fbSel    <= FB_128;
      irqEn    <= 1'b0;
      wrMask   <= '0;
      ready    <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (modeWr) begin
        modeAuto <= wrData[0];
        chain    <= wrData[3:1];
        fbSel    <= wrData[6:4];
      end
      if (wrEn && (wrAddr == A_IRQEN)) irqEn <= wrData[0];
      wrMask <= ((modeWr || goReq) ? '0 : wrMask) | strobe.inWr;
      if (modeWr)       err <= 1'b0;
      else if (inWrBad) err <= 1'b1;
      if (coreDone)     ready <= 1'b1;
      else if (outRead) ready <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == A_MODE)       rdData[6:0] = {fbSel, chain, modeAuto};
    else if (rdAddr == A_IRQEN) rdData[0]   = irqEn;
    else if (rdAddr == A_STAT)  rdData[2:0] = {err, coreBusy, ready};
    else if (rdOutHit)          rdData      = outWords[rdIdx];
  end

  assign irq = ready && irqEn;

  p_mask_in_permit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrMask & ~permit) == '0);
  p_bad_write_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    inWrBad && !goReq |=> err && (wrMask == $past(wrMask)));
  p_mask_fresh_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start |=> wrMask == $past(strobe.inWr));
  p_ready_on_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |=> ready);
  p_ready_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    ready && outRead && !coreDone |=> !ready);
endmodule

// File: rtl/csc_datapath.sv
`timescale 1ns/1ps
module csc_datapath
  import csc_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  dp_strobe_t strobe,
  output logic       coreBusy,
  output logic       coreDone,
  output blk_t       outWords
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [DATA_W-1:0] key0;
  blk_t              ivReg, inReg, opWord, pend;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             key0 <= '0;
    else if (strobe.keyWr) key0 <= strobe.data;
  end

  for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ivReg[g] <= '0;
        inReg[g] <= '0;
      end else begin
        if (strobe.ivWr[g]) ivReg[g] <= strobe.data;
        if (strobe.inWr[g]) inReg[g] <= strobe.data;
      end
    end
    assign opWord[g] = inReg[g] ^ key0 ^ (strobe.skipIv ? '0 : ivReg[g]);
  end

  assign coreDone = coreBusy && (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreBusy <= 1'b0;
      cnt      <= '0;
      pend     <= '0;
      outWords <= '0;
    end else if (strobe.start && !coreBusy) begin
      coreBusy <= 1'b1;
      cnt      <= CNT_W'(LATENCY - 1);
      pend     <= opWord;
    end else if (coreBusy) begin
      if (cnt == '0) begin
        coreBusy <= 1'b0;
        outWords <= pend;
      end else begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.start && !coreBusy |=> coreBusy && (cnt == CNT_W'(LATENCY - 1)));
  p_no_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreBusy && (cnt != '0) |=> coreBusy && (cnt == $past(cnt) - CNT_W'(1)) && $stable(pend));
  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreBusy) |-> (outWords == $past(pend)));
endmodule

// File: rtl/cipher_start_ctrl.sv
`timescale 1ns/1ps
module cipher_start_ctrl
  import csc_pkg::*;
#(
  parameter int LATENCY = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  dp_strobe_t strobe;
  logic       coreBusy, coreDone;
  blk_t       outWords;

  csc_ctrl u_ctrl (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .rdEn, .rdAddr,
    .coreBusy, .coreDone, .outWords, .strobe, .rdData, .irq
  );

  csc_datapath #(.LATENCY(LATENCY)) u_dp (
    .clk, .rstN, .strobe, .coreBusy, .coreDone, .outWords
  );
endmodule

// File: tb/sim_cipher_start_ctrl.sv
`timescale 1ns/1ps
module sim_cipher_start_ctrl;
  localparam int LAT = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [5:0]  rdAddr = 6'h03;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int    vecs = 0, errs = 0;
  string curReq = "R11";
  bit    finished = 1'b0;

  cipher_start_ctrl #(.LATENCY(LAT)) u0 (
    .clk, .rstN, .wrEn, .wrAddr, .wrData, .rdEn, .rdAddr, .rdData, .irq
  );

  always #2.5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int          mRem, mChain, mFb;
  bit          mAuto, mIrqEn, mReady, mErr;
  bit          mSeen[4];
  logic [31:0] mKey0, mIv[4], mIn[4], mPend[4], mOut[4];

  function automatic bit accepts(int ch, int fb, int i);
    if (ch != 3 || fb == 0) return 1'b1;
    if (fb == 1) return i < 2;
    return i == 0;
  endfunction

  function automatic logic [31:0] expRead(logic [5:0] a);
    if (a == 6'h01) return 32'(mAuto) | 32'(mChain << 1) | 32'(mFb << 4);
    if (a == 6'h02) return 32'(mIrqEn);
    if (a == 6'h03) return 32'(mReady) | (32'(mRem > 0) << 1) | (32'(mErr) << 2);
    if (a >= 6'h18 && a <= 6'h1B) return mOut[a - 6'h18];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mRem = 0; mChain = 0; mFb = 0; mAuto = 0; mIrqEn = 0; mReady = 0; mErr = 0;
      mKey0 = 0;
      for (int i = 0; i < 4; i++) begin
        mSeen[i] = 0; mIv[i] = 0; mIn[i] = 0; mPend[i] = 0; mOut[i] = 0;
      end
    end else begin
      bit full, go, startNow, doneNow;
      full = mAuto;
      for (int i = 0; i < 4; i++) if (accepts(mChain, mFb, i) && !mSeen[i]) full = 0;
      go = full || (wrEn && wrAddr == 6'h00 && wrData[0] && !mAuto);
      startNow = go && (mRem == 0);
      doneNow = (mRem == 1);
      if (startNow) begin
        for (int i = 0; i < 4; i++) mPend[i] = mIn[i] ^ mKey0 ^ (mChain == 0 ? 32'h0 : mIv[i]);
        mRem = LAT;
      end else if (mRem > 0) mRem--;
      if (doneNow) begin
        for (int i = 0; i < 4; i++) mOut[i] = mPend[i];
        mReady = 1;
      end else if (rdEn && rdAddr >= 6'h18 && rdAddr <= 6'h1B) mReady = 0;
      if (go) for (int i = 0; i < 4; i++) mSeen[i] = 0;
      if (wrEn) begin
        if (wrAddr == 6'h01) begin
          mAuto = wrData[0]; mChain = int'(wrData[3:1]); mFb = int'(wrData[6:4]);
          mErr = 0;
          for (int i = 0; i < 4; i++) mSeen[i] = 0;
        end
        if (wrAddr == 6'h02) mIrqEn = wrData[0];
        if (wrAddr == 6'h08) mKey0 = wrData;
        if (wrAddr >= 6'h10 && wrAddr <= 6'h13) mIv[wrAddr - 6'h10] = wrData;
        if (wrAddr >= 6'h14 && wrAddr <= 6'h17) begin
          if (accepts(mChain, mFb, int'(wrAddr - 6'h14))) begin
            mIn[wrAddr - 6'h14] = wrData; mSeen[wrAddr - 6'h14] = 1;
          end else mErr = 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      vecs++;
      if (rdData !== expRead(rdAddr)) begin
        errs++;
        $display("FAIL %s: rdData at addr %h is %h, expected %h", curReq, rdAddr, rdData, expRead(rdAddr));
      end
      vecs++;
      if (irq !== (mReady && mIrqEn)) begin
        errs++;
        $display("FAIL R9 (%s): irq is %b, expected %b", curReq, irq, mReady && mIrqEn);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rdEn = 1; rdAddr = a;
    @(negedge clk); d = rdData;
    @(posedge clk); #1;
    rdEn = 0; rdAddr = 6'h03;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    rdAddr = a; #1; d = rdData; rdAddr = 6'h03;
  endtask

  task automatic waitReady();
    logic [31:0] s;
    for (int k = 0; k < 40; k++) begin
      peek(6'h03, s);
      if (s[0]) break;
      idle(1);
    end
  endtask

  logic [31:0] v, key, ivw[4], inw[4];

  initial begin
    key = 32'hA5C3_0F1E;
    for (int i = 0; i < 4; i++) begin
      ivw[i] = 32'h1000_0001 * (i + 3);
      inw[i] = 32'h0BAD_F00D + 32'h0101_0101 * i;
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R11 reset values
    peek(6'h03, v); chk(v == 0, "R11 status", v, 0);
    peek(6'h01, v); chk(v == 0, "R11 mode", v, 0);
    peek(6'h02, v); chk(v == 0, "R11 irq enable", v, 0);
    chk(irq == 0, "R11 irq", 32'(irq), 0);
    idle(1);

    // R1 / R7 / R8 / R9: manual ECB, IV ignored
    curReq = "R1";
    wr(6'h01, 32'h00); wr(6'h02, 1); wr(6'h08, key);
    for (int i = 0; i < 4; i++) wr(6'h10 + 6'(i), ivw[i]);
    for (int i = 0; i < 4; i++) wr(6'h14 + 6'(i), inw[i]);
    wr(6'h00, 1);
    peek(6'h03, v); chk(v[1] == 1, "R1 busy after start", v, 32'h2);
    curReq = "R7";
    idle(LAT - 1);
    peek(6'h03, v); chk(v[0] == 0, "R7 not ready one cycle early", v, 32'h2);
    idle(1);
    peek(6'h03, v); chk(v == 32'h1, "R7 ready and idle at latency", v, 32'h1);
    chk(irq == 1, "R9 irq with enable", 32'(irq), 1);
    curReq = "R10";
    rd(6'h03, v);
    peek(6'h03, v); chk(v[0] == 1, "R10 status read keeps ready", v, 1);
    curReq = "R8";
    for (int i = 0; i < 4; i++) begin
      rd(6'h18 + 6'(i), v); chk(v == (inw[i] ^ key), "R8 ECB output", v, inw[i] ^ key);
    end
    peek(6'h03, v); chk(v[0] == 0, "R10 output read clears ready", v, 0);
    chk(irq == 0, "R9 irq drops with ready", 32'(irq), 0);

    // R8 CBC with IV, irq disabled
    curReq = "R8";
    wr(6'h01, 32'h02); wr(6'h02, 0); wr(6'h00, 1);
    waitReady();
    chk(irq == 0, "R9 irq masked", 32'(irq), 0);
    rd(6'h1A, v); chk(v == (inw[2] ^ key ^ ivw[2]), "R8 CBC output", v, inw[2] ^ key ^ ivw[2]);
    wr(6'h02, 1);

    // R2 / R3 / R4: automatic CFB-64
    curReq = "R4";
    wr(6'h01, 32'h17);
    wr(6'h14, 32'h1111_2222);
    wr(6'h16, 32'hDEAD_BEEF);
    peek(6'h03, v); chk(v == 32'h4, "R4 rejected word flags error, no start", v, 32'h4);
    curReq = "R2";
    wr(6'h15, 32'h3333_4444);
    peek(6'h03, v); chk(v[1] == 0, "R2 not yet busy on completing write", v, 0);
    idle(1);
    peek(6'h03, v); chk(v[1] == 1, "R2 busy one cycle after", v, 32'h2);
    waitReady();
    curReq = "R3";
    rd(6'h18, v); chk(v == (32'h1111_2222 ^ key ^ ivw[0]), "R3 CFB64 word0", v, 32'h1111_2222 ^ key ^ ivw[0]);
    rd(6'h1A, v); chk(v == (inw[2] ^ key ^ ivw[2]), "R4 rejected word not stored", v, inw[2] ^ key ^ ivw[2]);

    // R5: fresh writes needed after a start
    curReq = "R5";
    wr(6'h14, 32'h5555_0000);
    idle(3);
    peek(6'h03, v); chk(v[1] == 0, "R5 half set does not start", v, 0);
    wr(6'h15, 32'h6666_0000);
    // R6: trigger while busy is dropped
    curReq = "R6";
    wr(6'h14, 32'h7777_0000);
    wr(6'h15, 32'h8888_0000);
    waitReady();
    rd(6'h18, v); chk(v == (32'h5555_0000 ^ key ^ ivw[0]), "R6 running block unchanged", v, 32'h5555_0000 ^ key ^ ivw[0]);
    idle(5);
    peek(6'h03, v); chk(v[1] == 0, "R6 dropped trigger never runs", v, 0);
    wr(6'h00, 1); idle(1);
    peek(6'h03, v); chk(v[1] == 0, "R2 start write ignored in auto mode", v, 0);

    // R6 manual restart while busy
    wr(6'h01, 32'h04);
    wr(6'h00, 1);
    idle(4);
    wr(6'h00, 1);
    idle(4);
    peek(6'h03, v); chk(v[0] == 0, "R6 restart does not delay/advance", v, 0);
    idle(1);
    peek(6'h03, v); chk(v[0] == 1, "R6 ready at first start + latency", v, 1);
    rd(6'h19, v);

    // R3 CFB-8 auto: word 0 alone starts
    curReq = "R3";
    wr(6'h01, 32'h47);
    wr(6'h14, 32'h0F0F_0F0F);
    idle(1);
    peek(6'h03, v); chk(v[1] == 1, "R3 CFB8 single word starts", v, 32'h2);
    waitReady();
    rd(6'h18, v); chk(v == (32'h0F0F_0F0F ^ key ^ ivw[0]), "R3 CFB8 output", v, 32'h0F0F_0F0F ^ key ^ ivw[0]);

    // R3 CTR auto needs all four
    wr(6'h01, 32'h09);
    for (int i = 0; i < 3; i++) wr(6'h14 + 6'(i), inw[i]);
    idle(2);
    peek(6'h03, v); chk(v[1] == 0, "R3 CTR three words insufficient", v, 0);
    wr(6'h17, 32'hCAFE_0000);
    waitReady();
    rd(6'h1B, v); chk(v == (32'hCAFE_0000 ^ key ^ ivw[3]), "R3 CTR word3", v, 32'hCAFE_0000 ^ key ^ ivw[3]);
    curReq = "R4";
    wr(6'h01, 32'h00);
    peek(6'h03, v); chk(v[2] == 0, "R4 mode write clears error", v, 0);
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errs++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule